// File: doc/BRIEF.md
# 64-bit Integer Operate Execution Unit

This block is the integer execute stage of a load/store RISC core. Each cycle it may accept one 32-bit operate instruction word. It decodes the word and reads two source operands from an internal 32-entry, 64-bit register file. It computes an arithmetic, compare, logic, shift or bit-count result. On the same clock edge it writes that result to the destination register and presents it on a registered write-back output. The result is therefore visible to the next instruction with no forwarding needed.

The second operand is either a register or an 8-bit literal taken from the instruction. The literal is zero-extended to 64 bits. Compares produce a 0/1 value in a general register because the unit has no condition flags. Overflow is never trapped. Register 31 is a constant zero. A separate load write-back port lets the memory side of the core fill registers.

Instruction word layout:

| Field | Bits |
|---|---|
| opcode | [31:26] |
| source A (Ra) | [25:21] |
| source B (Rb) | [20:16] |
| literal | [20:13] |
| literal-select flag | [12] |
| function code | [11:5] |
| destination (Rc) | [4:0] |

The literal overlaps the source B field and the three bits below it.

Top module: `int_op_unit`

## Requirements
- R1: An instruction is executed only if opcode [31:26] equals OPC_INTOP (default 6'h10) and its function code is defined. The function code [11:5] is split into a group in fn[6:4] and a sub-code in fn[3:0]. The defined codes are: group 0 sub-codes 0-3, group 1 sub-codes 0-7, group 2 sub-codes 0-5, group 3 sub-codes 0-2 and group 4 sub-codes 0-2. Any other word writes no register, and wb_valid is low in the following cycle.
- R2: When bit 12 is 0, operand B is the register named by bits [20:16]. When bit 12 is 1, operand B is the 8-bit literal in bits [20:13], zero-extended to 64 bits.
- R3: An executed instruction writes its result to the register named by bits [4:0]. On the clock edge that accepts the instruction, wb_valid goes high, wb_reg takes Rc and wb_data takes the result. The next instruction reads the new value. In a cycle with no executed instruction, wb_valid is low.
- R4: Register 31 reads as zero. Writes to it, from either write port, are discarded.
- R5: Function 7'h00 computes A+B and 7'h01 computes A-B on 64 bits. Overflow wraps to the low 64 bits with no trap and no flag.
- R6: Function 7'h02 computes A+B and 7'h03 computes A-B on the low 32 bits. The 32-bit result is sign-extended to 64 bits.
- R7: Compares write 1 if the condition holds and 0 otherwise. The codes are 7'h10 equal, 7'h11 not equal, 7'h12 signed A<B, 7'h13 signed A<=B, 7'h14 signed A>B, 7'h15 signed A>=B, 7'h16 unsigned A<B and 7'h17 unsigned A<=B.
- R8: Logic codes are 7'h20 AND, 7'h21 NAND, 7'h22 OR, 7'h23 NOR, 7'h24 XOR and 7'h25 XNOR, each of A with B.
- R9: Shift codes are 7'h30 logical left, 7'h31 logical right and 7'h32 arithmetic right. Each shifts A by the low 6 bits of B.
- R10: Bit-count codes are 7'h40 population count, 7'h41 leading-zero count and 7'h42 trailing-zero count, each applied to B. The result is 0 to 64, and a zero input gives 64 for both zero counts.
- R11: When ld_we is high, ld_data is written to register ld_addr. If an executed instruction targets the same register in the same cycle, the instruction's result wins.
- R12: After reset all registers read zero, wb_valid is 0, wb_reg is 0 and wb_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | Instruction word on insn is presented this cycle |
| insn | input | 32 | Operate instruction word |
| ld_we | input | 1 | Load write-back enable |
| ld_addr | input | 5 | Load write-back register number |
| ld_data | input | 64 | Load write-back value |
| wb_valid | output | 1 | An instruction was executed on the last edge |
| wb_reg | output | 5 | Destination register of that instruction |
| wb_data | output | 64 | Result of that instruction |

## Verification
Every result appears on wb_valid, wb_reg and wb_data exactly one rising edge after the instruction is driven. A register written on that edge is read correctly by an instruction issued in the very next cycle. The bench drives inputs on the falling edge and samples the outputs on the following falling edge, so each sample falls after the capturing edge and before the next instruction. Reset is released after two further edges, and the bench waits past that window before its first reset-state check. Ignored writes, such as an illegal instruction, a write to register 31 or a load that loses to an instruction, are confirmed by reading the affected register back with a later instruction.

// File: rtl/int_op_pkg.sv
package int_op_pkg;

  localparam int OPC_HI  = 31;
  localparam int OPC_LO  = 26;
  localparam int RA_HI   = 25;
  localparam int RA_LO   = 21;
  localparam int RB_HI   = 20;
  localparam int RB_LO   = 16;
  localparam int LIT_HI  = 20;
  localparam int LIT_LO  = 13;
  localparam int LITF    = 12;
  localparam int FN_HI   = 11;
  localparam int FN_LO   = 5;
  localparam int RC_HI   = 4;
  localparam int RC_LO   = 0;

  typedef enum logic [2:0] {
    GRP_ARITH = 3'd0,
    GRP_CMP   = 3'd1,
    GRP_LOGIC = 3'd2,
    GRP_SHIFT = 3'd3,
    GRP_COUNT = 3'd4
  } grp_e;

  typedef struct packed {
    logic       legal;
    grp_e       grp;
    logic [3:0] sel;
    logic       use_lit;
    logic [4:0] ra;
    logic [4:0] rb;
    logic [4:0] rc;
    logic [7:0] lit;
  } dec_t;

endpackage

// File: rtl/int_op_decode.sv
module int_op_decode import int_op_pkg::*; #(
  parameter logic [5:0] OPC_INTOP = 6'h10
) (
  input  logic [31:0] insn,
  output dec_t        dec
);

  logic [6:0] fn;
  logic       fn_ok;

  always_comb begin
    fn          = insn[FN_HI:FN_LO];
    dec.ra      = insn[RA_HI:RA_LO];
    dec.rb      = insn[RB_HI:RB_LO];
    dec.rc      = insn[RC_HI:RC_LO];
    dec.lit     = insn[LIT_HI:LIT_LO];
    dec.use_lit = insn[LITF];
    dec.sel     = fn[3:0];
    case (fn[6:4])
      3'd0:    begin dec.grp = GRP_ARITH; fn_ok = (fn[3:0] <= 4'd3); end
      3'd1:    begin dec.grp = GRP_CMP;   fn_ok = (fn[3:0] <= 4'd7); end
      3'd2:    begin dec.grp = GRP_LOGIC; fn_ok = (fn[3:0] <= 4'd5); end
      3'd3:    begin dec.grp = GRP_SHIFT; fn_ok = (fn[3:0] <= 4'd2); end
      3'd4:    begin dec.grp = GRP_COUNT; fn_ok = (fn[3:0] <= 4'd2); end
      default: begin dec.grp = GRP_ARITH; fn_ok = 1'b0;              end
    endcase
    dec.legal = fn_ok && (insn[OPC_HI:OPC_LO] == OPC_INTOP);
  end

endmodule

// File: rtl/int_op_bitcount.sv
module int_op_bitcount #(
  parameter int XLEN = 64,
  localparam int CW  = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0] val,
  output logic [CW-1:0]   pop,
  output logic [CW-1:0]   lead,
  output logic [CW-1:0]   trail
);

  // population count
  always_comb begin
    pop = '0;
    for (int i = 0; i < XLEN; i++) pop = pop + CW'(val[i]);
  end

  // leading zeros: the highest set bit overrides all lower ones
  always_comb begin
    lead = CW'(XLEN);
    for (int i = 0; i < XLEN; i++)
      if (val[i]) lead = CW'(XLEN - 1 - i);
  end

  // trailing zeros: the lowest set bit overrides all higher ones
  always_comb begin
    trail = CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--)
      if (val[i]) trail = CW'(i);
  end

endmodule

// File: rtl/int_op_alu.sv
module int_op_alu import int_op_pkg::*; #(
  parameter int XLEN = 64
) (
  input  grp_e            grp,
  input  logic [3:0]      sel,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] res
);

  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);
  localparam int CW   = $clog2(XLEN + 1);

  logic            sub, eq, slt, ult, cond;
  logic [XLEN-1:0] addend, sum, arith_r, cmp_r, logic_r, shift_r, count_r;
  logic [SHW-1:0]  amt;
  logic [CW-1:0]   pop, lz, tz;

  int_op_bitcount #(.XLEN(XLEN)) cnt_i (
    .val  (opb),
    .pop  (pop),
    .lead (lz),
    .trail(tz)
  );

  // add / subtract, 64-bit or sign-extended 32-bit
  always_comb begin
    sub     = sel[0];
    addend  = sub ? ~opb : opb;
    sum     = opa + addend + {{(XLEN-1){1'b0}}, sub};
    arith_r = sel[1] ? {{HALF{sum[HALF-1]}}, sum[HALF-1:0]} : sum;
  end

  // compares
  always_comb begin
    eq  = (opa == opb);
    slt = ($signed(opa) < $signed(opb));
    ult = (opa < opb);
    case (sel[2:0])
      3'd0:    cond = eq;
      3'd1:    cond = !eq;
      3'd2:    cond = slt;
      3'd3:    cond = slt || eq;
      3'd4:    cond = !(slt || eq);
      3'd5:    cond = !slt;
      3'd6:    cond = ult;
      default: cond = ult || eq;
    endcase
    cmp_r = {{(XLEN-1){1'b0}}, cond};
  end

  // bitwise logic
  always_comb begin
    case (sel)
      4'd0:    logic_r = opa & opb;
      4'd1:    logic_r = ~(opa & opb);
      4'd2:    logic_r = opa | opb;
      4'd3:    logic_r = ~(opa | opb);
      4'd4:    logic_r = opa ^ opb;
      4'd5:    logic_r = ~(opa ^ opb);
      default: logic_r = '0;
    endcase
  end

  // shifts by the low bits of operand B
  always_comb begin
    amt = opb[SHW-1:0];
    case (sel)
      4'd0:    shift_r = opa << amt;
      4'd1:    shift_r = opa >> amt;
      4'd2:    shift_r = $signed(opa) >>> amt;
      default: shift_r = '0;
    endcase
  end

  // bit counts
  always_comb begin
    case (sel)
      4'd0:    count_r = {{(XLEN-CW){1'b0}}, pop};
      4'd1:    count_r = {{(XLEN-CW){1'b0}}, lz};
      4'd2:    count_r = {{(XLEN-CW){1'b0}}, tz};
      default: count_r = '0;
    endcase
  end

  always_comb begin
    case (grp)
      GRP_ARITH: res = arith_r;
      GRP_CMP:   res = cmp_r;
      GRP_LOGIC: res = logic_r;
      GRP_SHIFT: res = shift_r;
      GRP_COUNT: res = count_r;
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/int_op_regfile.sv
module int_op_regfile #(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [AW-1:0]   rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            op_we,
  input  logic [AW-1:0]   op_addr,
  input  logic [XLEN-1:0] op_data,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_data
);

  localparam int ZERO_REG = NREGS - 1;

  logic [XLEN-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == ZERO_REG) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      logic            en_op, en_ld, en;
      logic [XLEN-1:0] nxt;

      always_comb begin
        en_op = op_we && (op_addr == AW'(g));
        en_ld = ld_we && (ld_addr == AW'(g));
        en    = en_op || en_ld;
        nxt   = en_op ? op_data : ld_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  regs[g] <= '0;
        else if (en) regs[g] <= nxt;
      end
    end
  end

  assign rd_a_data = regs[rd_a_addr];
  assign rd_b_data = regs[rd_b_addr];

  // R3: an instruction result is readable on the following cycle
  assert_op_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_we) && ($past(op_addr) != AW'(ZERO_REG)) && (rd_a_addr == $past(op_addr)))
      |-> (rd_a_data == $past(op_data)));

  // R11: a load write that no instruction overrides is readable next cycle
  assert_ld_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld_we) && !($past(op_we) && ($past(op_addr) == $past(ld_addr)))
      && ($past(ld_addr) != AW'(ZERO_REG)) && (rd_a_addr == $past(ld_addr)))
      |-> (rd_a_data == $past(ld_data)));

endmodule

// File: rtl/int_op_unit.sv
module int_op_unit import int_op_pkg::*; #(
  parameter int          XLEN      = 64,
  parameter int          NREGS     = 32,
  parameter int          LIT_W     = 8,
  parameter logic [5:0]  OPC_INTOP = 6'h10,
  localparam int         AW        = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [31:0]     insn,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_reg,
  output logic [XLEN-1:0] wb_data
);

  localparam int HALF     = XLEN / 2;
  localparam int ZERO_REG = NREGS - 1;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dec_t            dec;
  logic [XLEN-1:0] ra_data, rb_data, opb, result;
  logic            issue_ok, op_we;

  int_op_decode #(.OPC_INTOP(OPC_INTOP)) dec_i (
    .insn(insn),
    .dec (dec)
  );

  int_op_regfile #(.XLEN(XLEN), .NREGS(NREGS)) rf_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_a_addr(dec.ra),
    .rd_a_data(ra_data),
    .rd_b_addr(dec.rb),
    .rd_b_data(rb_data),
    .op_we    (op_we),
    .op_addr  (dec.rc),
    .op_data  (result),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data)
  );

  always_comb begin
    opb      = dec.use_lit ? {{(XLEN-LIT_W){1'b0}}, dec.lit} : rb_data;
    issue_ok = issue_valid && dec.legal;
    op_we    = issue_ok && (dec.rc != AW'(ZERO_REG));
  end

  int_op_alu #(.XLEN(XLEN)) alu_i (
    .grp(dec.grp),
    .sel(dec.sel),
    .opa(ra_data),
    .opb(opb),
    .res(result)
  );

  // write-back output register
  logic            wb_valid_d;
  logic [AW-1:0]   wb_reg_d;
  logic [XLEN-1:0] wb_data_d;

  always_comb begin
    wb_valid_d = issue_ok;
    wb_reg_d   = issue_ok ? dec.rc : wb_reg;
    wb_data_d  = issue_ok ? result : wb_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_valid <= 1'b0;
      wb_reg   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= wb_valid_d;
      wb_reg   <= wb_reg_d;
      wb_data  <= wb_data_d;
    end
  end

  // R1: an undefined word never produces a write-back
  assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_valid && !dec.legal) |=> !wb_valid);

  // R3: an executed word reports its destination on the next cycle
  assert_dest_report_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_valid && dec.legal) |=> (wb_valid && (wb_reg == $past(insn[4:0]))));

  // R6: the 32-bit forms deliver a sign-extended value
  assert_long_sext_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_ok && (dec.grp == GRP_ARITH) && dec.sel[1])
      |=> (wb_data[XLEN-1:HALF] == {HALF{wb_data[HALF-1]}}));

  // R7: a compare delivers only 0 or 1
  assert_cmp_bool_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_ok && (dec.grp == GRP_CMP)) |=> (wb_data[XLEN-1:1] == '0));

  // R10: a bit count never exceeds the word width
  assert_count_range_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_ok && (dec.grp == GRP_COUNT)) |=> (wb_data <= XLEN));

endmodule

// File: tb/int_op_unit_tb_top.sv
`timescale 1ns/1ps
module int_op_unit_tb_top;

  localparam logic [5:0] OPC = 6'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [31:0] insn;
  logic        ld_we;
  logic [4:0]  ld_addr;
  logic [63:0] ld_data;
  logic        wb_valid;
  logic [4:0]  wb_reg;
  logic [63:0] wb_data;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  int_op_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .insn       (insn),
    .ld_we      (ld_we),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .wb_data    (wb_data)
  );

  typedef struct packed {
    logic [4:0]  ra;
    logic [7:0]  b;
    logic        lit;
    logic [6:0]  fn;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 39;
  // registers: R1=5 R2=-5 R3=max R4=min R5=0x7FFFFFFF R6=00F0..0100 R7=0
  localparam vec_t VECS [NV] = '{
    '{5'd1, 8'h02, 1'b0, 7'h00, 64'h0000000000000000, 4'd5},  // R5 add
    '{5'd3, 8'h01, 1'b1, 7'h00, 64'h8000000000000000, 4'd5},  // R5 wrap
    '{5'd4, 8'h01, 1'b0, 7'h01, 64'h7FFFFFFFFFFFFFFB, 4'd5},  // R5 sub wrap
    '{5'd5, 8'h01, 1'b1, 7'h02, 64'hFFFFFFFF80000000, 4'd6},  // R6
    '{5'd7, 8'h01, 1'b1, 7'h03, 64'hFFFFFFFFFFFFFFFF, 4'd6},  // R6
    '{5'd1, 8'h02, 1'b0, 7'h03, 64'h000000000000000A, 4'd6},  // R6
    '{5'd1, 8'h05, 1'b1, 7'h10, 64'h1, 4'd7},                 // R7 eq
    '{5'd1, 8'h05, 1'b1, 7'h11, 64'h0, 4'd7},                 // R7 ne
    '{5'd2, 8'h01, 1'b0, 7'h12, 64'h1, 4'd7},                 // R7 lt
    '{5'd2, 8'h01, 1'b0, 7'h16, 64'h0, 4'd7},                 // R7 ult
    '{5'd1, 8'h05, 1'b1, 7'h13, 64'h1, 4'd7},                 // R7 le
    '{5'd1, 8'h04, 1'b1, 7'h17, 64'h0, 4'd7},                 // R7 ule
    '{5'd1, 8'h02, 1'b0, 7'h14, 64'h1, 4'd7},                 // R7 gt
    '{5'd2, 8'h01, 1'b0, 7'h15, 64'h0, 4'd7},                 // R7 ge
    '{5'd4, 8'h03, 1'b0, 7'h14, 64'h0, 4'd7},                 // R7 min>max
    '{5'd3, 8'hA5, 1'b1, 7'h20, 64'h00000000000000A5, 4'd8},  // R8 and
    '{5'd1, 8'h0F, 1'b1, 7'h21, 64'hFFFFFFFFFFFFFFFA, 4'd8},  // R8 nand
    '{5'd6, 8'h01, 1'b0, 7'h22, 64'h00F0000000000105, 4'd8},  // R8 or
    '{5'd7, 8'h07, 1'b0, 7'h23, 64'hFFFFFFFFFFFFFFFF, 4'd8},  // R8 nor
    '{5'd2, 8'h01, 1'b0, 7'h24, 64'hFFFFFFFFFFFFFFFE, 4'd8},  // R8 xor
    '{5'd3, 8'h04, 1'b0, 7'h25, 64'h0000000000000000, 4'd8},  // R8 xnor
    '{5'd1, 8'h04, 1'b1, 7'h30, 64'h0000000000000050, 4'd9},  // R9 sll
    '{5'd1, 8'h43, 1'b1, 7'h30, 64'h0000000000000028, 4'd9},  // R9 low 6 bits
    '{5'd4, 8'h3F, 1'b1, 7'h31, 64'h0000000000000001, 4'd9},  // R9 srl
    '{5'd4, 8'h04, 1'b1, 7'h32, 64'hF800000000000000, 4'd9},  // R9 sra
    '{5'd2, 8'h01, 1'b1, 7'h32, 64'hFFFFFFFFFFFFFFFD, 4'd9},  // R9 sra neg
    '{5'd2, 8'h01, 1'b0, 7'h31, 64'h07FFFFFFFFFFFFFF, 4'd9},  // R9 srl by reg
    '{5'd0, 8'h06, 1'b0, 7'h40, 64'd5,  4'd10},               // R10 pop
    '{5'd0, 8'hFF, 1'b1, 7'h40, 64'd8,  4'd10},               // R10 pop lit
    '{5'd0, 8'h06, 1'b0, 7'h41, 64'd8,  4'd10},               // R10 clz
    '{5'd0, 8'h06, 1'b0, 7'h42, 64'd8,  4'd10},               // R10 ctz
    '{5'd0, 8'h07, 1'b0, 7'h41, 64'd64, 4'd10},               // R10 clz zero
    '{5'd0, 8'h07, 1'b0, 7'h42, 64'd64, 4'd10},               // R10 ctz zero
    '{5'd0, 8'h04, 1'b0, 7'h41, 64'd0,  4'd10},               // R10 clz msb
    '{5'd0, 8'h04, 1'b0, 7'h42, 64'd63, 4'd10},               // R10 ctz msb
    '{5'd0, 8'h03, 1'b0, 7'h40, 64'd63, 4'd10},               // R10 pop 63
    '{5'd31, 8'h7E, 1'b1, 7'h22, 64'h7E, 4'd4},               // R4 read R31
    '{5'd31, 8'h1F, 1'b0, 7'h00, 64'h0,  4'd4},               // R4 R31+R31
    '{5'd5, 8'h80, 1'b1, 7'h24, 64'h000000007FFFFF7F, 4'd2}   // R2 zero-extend
  };

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] ra,
                                     input logic [7:0] b, input logic lit,
                                     input logic [6:0] fn, input logic [4:0] rc);
    mk = {opc, ra, (lit ? b : {b[4:0], 3'b000}), lit, fn, rc};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] w, output logic v,
                        output logic [4:0] r, output logic [63:0] d);
    @(negedge clk);
    issue_valid = 1'b1;
    insn        = w;
    @(negedge clk);
    issue_valid = 1'b0;
    v = wb_valid;
    r = wb_reg;
    d = wb_data;
  endtask

  task automatic load_reg(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    ld_we   = 1'b1;
    ld_addr = a;
    ld_data = d;
    @(negedge clk);
    ld_we   = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic        v;
    logic [4:0]  r;
    logic [63:0] d;

    rst_n = 1'b0; issue_valid = 1'b0; insn = '0;
    ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state of the outputs and a register
    check(wb_valid == 1'b0 && wb_reg == 5'd0 && wb_data == 64'd0,
          "R12 reset outputs", {58'd0, wb_valid, wb_reg}, 64'd0);
    run_op(mk(OPC, 5'd8, 8'h00, 1'b1, 7'h22, 5'd9), v, r, d);
    check(v && d == 64'd0, "R12 reset register R8", d, 64'd0);

    load_reg(5'd1, 64'h0000000000000005);
    load_reg(5'd2, 64'hFFFFFFFFFFFFFFFB);
    load_reg(5'd3, 64'h7FFFFFFFFFFFFFFF);
    load_reg(5'd4, 64'h8000000000000000);
    load_reg(5'd5, 64'h000000007FFFFFFF);
    load_reg(5'd6, 64'h00F0000000000100);
    load_reg(5'd7, 64'h0000000000000000);

    for (int i = 0; i < NV; i++) begin
      run_op(mk(OPC, VECS[i].ra, VECS[i].b, VECS[i].lit, VECS[i].fn, 5'd10), v, r, d);
      check(v === 1'b1 && r === 5'd10 && d === VECS[i].exp,
            $sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
    end

    // R4: writes to register 31 from both ports are discarded
    load_reg(5'd31, 64'h123);
    run_op(mk(OPC, 5'd1, 8'h00, 1'b1, 7'h22, 5'd31), v, r, d);
    run_op(mk(OPC, 5'd31, 8'h00, 1'b1, 7'h22, 5'd10), v, r, d);
    check(v && d == 64'd0, "R4 register 31 after writes", d, 64'd0);

    // R3: back-to-back dependent instructions, then an idle cycle
    @(negedge clk);
    issue_valid = 1'b1;
    insn = mk(OPC, 5'd1, 8'h30, 1'b1, 7'h22, 5'd12);
    @(negedge clk);
    check(wb_valid && wb_reg == 5'd12 && wb_data == 64'h35, "R3 first result", wb_data, 64'h35);
    insn = mk(OPC, 5'd12, 8'h0C, 1'b0, 7'h00, 5'd13);
    @(negedge clk);
    issue_valid = 1'b0;
    check(wb_valid && wb_reg == 5'd13 && wb_data == 64'h6A, "R3 dependent result", wb_data, 64'h6A);
    @(negedge clk);
    check(wb_valid == 1'b0, "R3 idle cycle wb_valid", {63'd0, wb_valid}, 64'd0);

    // R1: undefined opcode or function writes nothing
    load_reg(5'd13, 64'h77);
    run_op(mk(6'h11, 5'd1, 8'h01, 1'b0, 7'h00, 5'd13), v, r, d);
    check(v == 1'b0, "R1 wrong opcode wb_valid", {63'd0, v}, 64'd0);
    run_op(mk(OPC, 5'd1, 8'h01, 1'b0, 7'h7F, 5'd13), v, r, d);
    check(v == 1'b0, "R1 undefined function wb_valid", {63'd0, v}, 64'd0);
    run_op(mk(OPC, 5'd1, 8'h01, 1'b0, 7'h06, 5'd13), v, r, d);
    check(v == 1'b0, "R1 undefined arith sub-code wb_valid", {63'd0, v}, 64'd0);
    run_op(mk(OPC, 5'd13, 8'h00, 1'b1, 7'h22, 5'd10), v, r, d);
    check(v && d == 64'h77, "R1 register untouched", d, 64'h77);

    // R11: load port alone, and losing to an instruction on the same register
    load_reg(5'd15, 64'hABCD);
    run_op(mk(OPC, 5'd15, 8'h00, 1'b1, 7'h22, 5'd10), v, r, d);
    check(v && d == 64'hABCD, "R11 load write", d, 64'hABCD);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 5'd14; ld_data = 64'h99;
    issue_valid = 1'b1;
    insn = mk(OPC, 5'd31, 8'h11, 1'b1, 7'h22, 5'd14);
    @(negedge clk);
    ld_we = 1'b0; issue_valid = 1'b0;
    run_op(mk(OPC, 5'd14, 8'h00, 1'b1, 7'h22, 5'd10), v, r, d);
    check(v && d == 64'h11, "R11 instruction wins collision", d, 64'h11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule